// File: doc/BRIEF.md
# Video Output Sync Mixer

This block is the last digital stage before three video DACs. Every clock it takes three 8-bit colour components (R/G/B, or luma and two colour-difference values) and one "sync byte". For each channel it forms the sum of a programmable constant offset, the component, and the sync byte if that channel is allowed to carry sync. The sum wraps modulo 256 and never saturates. One clock later the three codes appear at registered outputs, together with a matching valid strobe.

Because the sum wraps, sync can be carried inside a colour channel. Set a black-level offset on that channel, then pick a sync byte that brings the total back to exactly zero. For example, with an offset of 76, a sync byte of 180 gives 76 + 180 = 256, which wraps to 0. This yields sync-on-green, or a luma sync tip, with no extra pin. During active video the sync byte is zero. Colour-difference channels use an offset of 128 so that their black level sits at mid-scale. While the pixel strobe is low, the components are ignored, so each channel outputs its blanking level: the offset plus the enabled sync byte.

The block has three offset registers and one mode register, written through a simple write-enable port.

Top module: `vid_sync_mixer`

## Requirements
- R1: While `rst_n` is low, all three DAC codes are 0 and `dac_vld` is 0. All offset registers and the mode register reset to 0.
- R2: The code of channel k equals (offset k + component k + gated sync) mod 256. It appears on the clock edge after the inputs are sampled, so the latency is one clock.
- R3: Each channel has its own sync enable in the mode register. Bit 3 enables sync on channel 0, bit 2 on channel 1, and bit 1 on channel 2. When a channel's bit is 0, the sync byte adds nothing to that channel.
- R4: The addition wraps and does not saturate. With offset 76, sync enabled and sync byte 180 during blanking, the code is exactly 0.
- R5: When `pix_vld` is low, the components are treated as zero. Each code is then offset plus the enabled sync byte.
- R6: `dac_vld` equals `pix_vld` delayed by exactly one clock.
- R7: A configuration write selects its target by `cfg_addr`: 0, 1 and 2 select the channel 0, 1 and 2 offsets, and 3 selects the mode register. A write sampled on one clock edge applies to pixels sampled from the next edge onward. A pixel sampled on the same edge as the write still uses the old value.
- R8: Mode bit 4 selects signed (sign-extended) arithmetic on channels 1 and 2. The outputs are 8 bits wide and the sum is taken modulo 256, so the codes are identical with this bit set or clear.
- R9: Mode bits 0, 5, 6 and 7 are stored but have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_vld | input | 1 | Active-pixel strobe; when low, the components are ignored |
| comp0 | input | 8 | Channel 0 component (R or Y) |
| comp1 | input | 8 | Channel 1 component (G or Pb) |
| comp2 | input | 8 | Channel 2 component (B or Pr) |
| sync_byte | input | 8 | Sync level, added to channels whose sync enable is set |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Write target: 0 to 2 select the offsets, 3 selects the mode register |
| cfg_wdata | input | 8 | Configuration write data |
| dac0 | output | 8 | Registered code for channel 0 |
| dac1 | output | 8 | Registered code for channel 1 |
| dac2 | output | 8 | Registered code for channel 2 |
| dac_vld | output | 1 | `pix_vld` delayed by one clock |

## Verification
The hardest cases to reach from the ports are two. The first is a configuration write that lands on the same edge as a pixel, where the pixel must still use the old setting. The second is an exact wrap to zero, where the offset and the sync byte sum to precisely 256. The stimulus reaches the first by mixing random register writes into a random pixel stream on every cycle, so writes often collide with active pixels. It reaches the second by programming offset 76 and driving sync byte 180 on a blanked cycle, and checking the zero code directly as well as against the reference model. The signed-mode and unused-bit cases are checked by running the same kinds of pixels with those mode bits set and comparing against a model that ignores them.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  // three output channels, fixed by the port list
  localparam int NCH    = 3;
  localparam int CFG_AW = 2;

  // configuration targets
  typedef enum logic [CFG_AW-1:0] {
    CFG_OFF0 = 2'd0,
    CFG_OFF1 = 2'd1,
    CFG_OFF2 = 2'd2,
    CFG_MODE = 2'd3
  } cfg_sel_e;

  // mode bit: signed arithmetic on the colour-difference lanes
  localparam int MODE_SGN = 4;

  // mode bit that lets channel ch carry the sync byte (ch0 -> 3, ch1 -> 2, ch2 -> 1)
  function automatic int sync_en_bit(input int ch);
    return 3 - ch;
  endfunction
endpackage

// File: rtl/vsm_cfg_regs.sv
module vsm_cfg_regs
  import vsm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CFG_AW-1:0]      addr,
  input  logic [W-1:0]           wdata,
  output logic [NCH-1:0][W-1:0]  off_q,
  output logic [W-1:0]           mode_q
);
  // one offset register per channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_off
    logic hit;
    assign hit = we && (addr == CFG_AW'(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   off_q[ch] <= '0;
      else if (hit) off_q[ch] <= wdata;
    end
  end

  logic mode_hit;
  assign mode_hit = we && (addr == CFG_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= '0;
    else if (mode_hit) mode_q <= wdata;
  end
endmodule

// File: rtl/vsm_lane.sv
module vsm_lane #(
  parameter int W     = 8,
  parameter bit SX_OK = 1'b0   // lane accepts signed operands
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic [W-1:0] comp,
  input  logic [W-1:0] sync,
  input  logic [W-1:0] off,
  input  logic         en,
  input  logic         sx,
  output logic [W-1:0] code
);
  localparam int XW = W + 2;

  // widen an operand, sign-extending it when asked
  function automatic logic [XW-1:0] widen(input logic [W-1:0] v, input logic s);
    return s ? {{(XW-W){v[W-1]}}, v} : {{(XW-W){1'b0}}, v};
  endfunction

  logic         sx_eff;
  logic [W-1:0] comp_g;
  logic [W-1:0] sync_g;
  logic [W-1:0] total;

  assign sx_eff = SX_OK && sx;
  assign comp_g = vld ? comp : '0;
  assign sync_g = sync & {W{en}};
  // the wide sum is cut to W bits, which gives wrap-around with no clamping
  assign total  = W'(widen(off, sx_eff) + widen(comp_g, sx_eff) + widen(sync_g, 1'b0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code <= '0;
    else        code <= total;
  end
endmodule

// File: rtl/vid_sync_mixer.sv
module vid_sync_mixer
  import vsm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic [W-1:0]      comp0,
  input  logic [W-1:0]      comp1,
  input  logic [W-1:0]      comp2,
  input  logic [W-1:0]      sync_byte,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [W-1:0]      cfg_wdata,
  output logic [W-1:0]      dac0,
  output logic [W-1:0]      dac1,
  output logic [W-1:0]      dac2,
  output logic              dac_vld
);
  logic [NCH-1:0][W-1:0] off_q;
  logic [W-1:0]          mode_q;
  logic [NCH-1:0][W-1:0] comp_bus;
  logic [NCH-1:0][W-1:0] lane_code;

  assign comp_bus = {comp2, comp1, comp0};

  vsm_cfg_regs #(.W(W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .off_q (off_q),
    .mode_q(mode_q)
  );

  // channel 0 is luma or red and stays unsigned; channels 1 and 2 may be signed
  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    vsm_lane #(.W(W), .SX_OK(ch != 0)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .vld  (pix_vld),
      .comp (comp_bus[ch]),
      .sync (sync_byte),
      .off  (off_q[ch]),
      .en   (mode_q[sync_en_bit(ch)]),
      .sx   (mode_q[MODE_SGN]),
      .code (lane_code[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_vld <= 1'b0;
    else        dac_vld <= pix_vld;
  end

  assign dac0 = lane_code[0];
  assign dac1 = lane_code[1];
  assign dac2 = lane_code[2];
endmodule

// File: rtl/vid_sync_mixer_chk.sv
module vid_sync_mixer_chk #(
  parameter int W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pix_vld,
  input logic [W-1:0]       comp0,
  input logic [W-1:0]       comp1,
  input logic [W-1:0]       comp2,
  input logic [W-1:0]       sync_byte,
  input logic               cfg_we,
  input logic [1:0]         cfg_addr,
  input logic [W-1:0]       cfg_wdata,
  input logic [W-1:0]       dac0,
  input logic [W-1:0]       dac1,
  input logic [W-1:0]       dac2,
  input logic               dac_vld,
  input logic [2:0][W-1:0]  off_q,
  input logic [W-1:0]       mode_q
);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (dac0 == '0 && dac1 == '0 && dac2 == '0 && !dac_vld));

  a_r6_vld_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac_vld == $past(pix_vld)));

  a_r2_ch0_sum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac0 == W'($past(off_q[0]) + ($past(pix_vld) ? $past(comp0) : '0)
                        + ($past(mode_q[3]) ? $past(sync_byte) : '0))));

  a_r2_ch1_sum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac1 == W'($past(off_q[1]) + ($past(pix_vld) ? $past(comp1) : '0)
                        + ($past(mode_q[2]) ? $past(sync_byte) : '0))));

  a_r3_ch2_sum: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dac2 == W'($past(off_q[2]) + ($past(pix_vld) ? $past(comp2) : '0)
                        + ($past(mode_q[1]) ? $past(sync_byte) : '0))));

  a_r4_sync_tip_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_vld && mode_q[3] && off_q[0] == W'(76) && sync_byte == W'(180)) |=> (dac0 == '0));

  a_r7_off0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd0) |=> (off_q[0] == $past(cfg_wdata)));

  a_r7_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd3) |=> (mode_q == $past(cfg_wdata)));

  a_r7_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(off_q) && $stable(mode_q)));
endmodule

bind vid_sync_mixer vid_sync_mixer_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_vld  (pix_vld),
  .comp0    (comp0),
  .comp1    (comp1),
  .comp2    (comp2),
  .sync_byte(sync_byte),
  .cfg_we   (cfg_we),
  .cfg_addr (cfg_addr),
  .cfg_wdata(cfg_wdata),
  .dac0     (dac0),
  .dac1     (dac1),
  .dac2     (dac2),
  .dac_vld  (dac_vld),
  .off_q    (off_q),
  .mode_q   (mode_q)
);

// File: tb/vid_sync_mixer_test.sv
module vid_sync_mixer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_vld = 1'b0;
  logic [7:0] comp0 = '0, comp1 = '0, comp2 = '0, sync_byte = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] dac0, dac1, dac2;
  logic       dac_vld;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;

  // reference model state
  int m_off[3] = '{0, 0, 0};
  int m_mode   = 0;
  int exp_c[3] = '{0, 0, 0};
  int exp_v    = 0;

  always #4 clk = ~clk;

  vid_sync_mixer uut (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld),
    .comp0(comp0), .comp1(comp1), .comp2(comp2), .sync_byte(sync_byte),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .dac0(dac0), .dac1(dac1), .dac2(dac2), .dac_vld(dac_vld)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: check last cycle's prediction, drive new inputs, update model
  task automatic tick(input string req, input bit v, input int c0, input int c1, input int c2,
                      input int sy, input bit we, input int a, input int wd);
    int c[3];
    @(negedge clk);
    check(req, "dac0", int'(dac0), exp_c[0]);
    check(req, "dac1", int'(dac1), exp_c[1]);
    check(req, "dac2", int'(dac2), exp_c[2]);
    check(req, "dac_vld", int'(dac_vld), exp_v);
    pix_vld = v; comp0 = c0[7:0]; comp1 = c1[7:0]; comp2 = c2[7:0];
    sync_byte = sy[7:0]; cfg_we = we; cfg_addr = a[1:0]; cfg_wdata = wd[7:0];
    c[0] = c0 & 255; c[1] = c1 & 255; c[2] = c2 & 255;
    for (int ch = 0; ch < 3; ch++) begin
      int s;
      s = m_off[ch] + (v ? c[ch] : 0) + (((m_mode >> (3 - ch)) & 1) != 0 ? (sy & 255) : 0);
      exp_c[ch] = s % 256;
    end
    exp_v = v ? 1 : 0;
    if (we) begin
      if ((a & 3) == 3) m_mode = wd & 255;
      else              m_off[a & 3] = wd & 255;
    end
  endtask

  task automatic idle(input string req);
    tick(req, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input string req, input int a, input int wd);
    tick(req, 0, 0, 0, 0, 0, 1, a, wd);
  endtask

  initial begin
    // R1: reset state
    idle("R1"); idle("R1");
    rst_n = 1'b1;
    idle("R1");

    // R7: program offsets and mode through the write port
    wr("R7", 0, 76); wr("R7", 1, 128); wr("R7", 2, 128); wr("R7", 3, 8'h08);
    idle("R7");
    check("R7", "dac1 offset readout", int'(dac1), 128);

    // R4: sync tip wraps to exactly zero
    tick("R4", 0, 0, 0, 0, 180, 0, 0, 0);
    idle("R4");
    check("R4", "dac0 sync tip", int'(dac0), 0);
    check("R4", "dac1 mid-scale", int'(dac1), 128);

    // R2: active pixels, sync byte zero
    for (int i = 0; i < 20; i++)
      tick("R2", 1, 0 + i * 9, 255 - i * 7, i * 13, 0, 0, 0, 0);

    // R5: blanking ignores components
    for (int i = 0; i < 6; i++) tick("R5", 0, 200, 99, 17 + i, 0, 0, 0, 0);
    idle("R5");
    check("R5", "dac2 blank level", int'(dac2), 128);

    // R3: each sync enable on its own, then all together
    wr("R3", 3, 8'h04);
    for (int i = 0; i < 4; i++) tick("R3", i % 2, 10, 20, 30, 50 + i, 0, 0, 0);
    wr("R3", 3, 8'h02);
    for (int i = 0; i < 4; i++) tick("R3", i % 2, 10, 20, 30, 200 + i, 0, 0, 0);
    wr("R3", 3, 8'h0E);
    for (int i = 0; i < 4; i++) tick("R3", 1, 250, 140, 3, 129 + i, 0, 0, 0);
    idle("R3");

    // R6: strobe pattern
    for (int i = 0; i < 10; i++) tick("R6", (i % 3) == 0, i, i, i, 0, 0, 0, 0);

    // R8: signed mode, negative chroma values
    wr("R8", 3, 8'h1E);
    for (int i = 0; i < 16; i++)
      tick("R8", 1, i * 11, 128 + i * 5, 255 - i * 3, (i % 4 == 0) ? 180 : 0, 0, 0, 0);

    // R9: stored but unused mode bits
    wr("R9", 3, 8'hE1);
    for (int i = 0; i < 10; i++) tick("R9", i % 2, 77 * i, 33 * i, 5 * i, 91, 0, 0, 0);

    // R7: writes coinciding with active pixels
    for (int i = 0; i < 8; i++)
      tick("R7", 1, 40, 50, 60, 7, 1, i % 4, 16 * i + 3);

    // R2: random traffic including writes
    for (int i = 0; i < 400; i++)
      tick("R2", 1'($urandom), int'($urandom % 256), int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 256), ($urandom % 5) == 0, int'($urandom % 4), int'($urandom % 256));
    idle("R2"); idle("R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule